// File: doc/BRIEF.md
# Byte-Addressed Data Memory Port

This block is the data-side memory of a small processor, together with the wrapper that sits between the pipeline and the storage. The processor supplies a base register value and a signed 16-bit displacement. The block forms the byte address from them. A 2-bit operation code selects one of four operations: a full-word fetch, or a store of one byte, two bytes or four bytes. Stores take effect at the next rising clock edge, and only the byte lanes that the store covers are changed.

A fetch is combinational from the stored word. The wrapper then takes out a single byte, a halfword or the whole word, and extends a sub-word value with either its sign or with zeros, as the load form asks. Bytes inside a word are big-endian. Storage is a parameterised number of 32-bit words that reset clears, and address bits above the word index are ignored.

An access that breaks its alignment rule is not trapped. It raises a flag in the same cycle, and a store in that state changes nothing. The design has no state machine. Each access is decided inside one cycle: an address adder, an alignment check, a lane-enable generator, the register array and a load aligner.

Top module: `bytemem_port`

## Requirements
- R1: The effective address `eff_addr` equals `base` plus `offset` sign-extended to 32 bits, modulo 2^32, and it selects the word and the byte that the access uses.
- R2: With `en` high and `op`=00 (fetch) and `ld_size`=1x (word), `rdata` equals the stored word at word index `eff_addr[IDXW+1:2]`, combinationally. If `eff_addr[1:0]` is not 0, `misalign` is 1 and `rdata` is 0.
- R3: `op`=01 with `en` high writes `wdata[7:0]` into the single addressed byte only, on the next rising edge. Byte offset 0 is bits 31:24, offset 1 is bits 23:16, offset 2 is bits 15:8 and offset 3 is bits 7:0. The other three bytes keep their values.
- R4: `op`=10 with `en` high writes `wdata[15:0]` into bits 31:16 when `eff_addr[1]`=0, or into bits 15:0 when it is 1. If `eff_addr[0]`=1, `misalign` is 1 and the word is left unchanged.
- R5: `op`=11 with `en` high writes all of `wdata`. If `eff_addr[1:0]` is not 0, `misalign` is 1 and the word is left unchanged.
- R6: With `en` low, no word changes, `rdata` is 0 and `misalign` is 0, whatever the other inputs are.
- R7: A fetch with `ld_size`=00 (byte) returns the addressed byte in `rdata[7:0]`. The upper 24 bits are copies of bit 7 of that byte when `ld_zext`=0, and zeros when `ld_zext`=1. No byte offset is misaligned.
- R8: A fetch with `ld_size`=01 (halfword) returns bits 31:16 of the word when `eff_addr[1]`=0, or bits 15:0 when it is 1. The value is sign-extended when `ld_zext`=0 and zero-extended when `ld_zext`=1. If `eff_addr[0]`=1, `misalign` is 1 and `rdata` is 0.
- R9: After reset, every word reads as 0.
- R10: `rdata` is 0 during any store operation (`op` not 00).
- R11: Address bits above `IDXW+1` are ignored: an address and that address plus 4*DEPTH reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores commit on the rising edge |
| rst_n | input | 1 | Active-low reset; clears all words |
| en | input | 1 | Access enable |
| op | input | 2 | 00 fetch word, 01 store byte, 10 store halfword, 11 store word |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| ld_size | input | 2 | Load width on a fetch: 00 byte, 01 halfword, 1x word |
| ld_zext | input | 1 | 1 = zero-extend sub-word loads, 0 = sign-extend |
| wdata | input | 32 | Store data; sub-word stores use the low bits |
| eff_addr | output | 32 | Computed byte address |
| rdata | output | 32 | Aligned and extended load result |
| misalign | output | 1 | Alignment rule broken by the current access |

## Verification
The alignment check and the lane enables act in the same cycle. A misaligned halfword or word store must be flagged and also write nothing, even though the address still selects a real word. The bench mixes such misaligned stores with aligned ones, using random displacements around word boundaries. Each store is judged twice: by the flag in its own cycle, and by later fetches of that word, which are compared with a bench model in which the misaligned store never took place.

// File: rtl/mem_port_pkg.sv
package mem_port_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int OFS_W  = 16;

    typedef enum logic [1:0] {
        OP_FETCH    = 2'b00,
        OP_ST_BYTE  = 2'b01,
        OP_ST_HALF  = 2'b10,
        OP_ST_WORD  = 2'b11
    } mem_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } ld_size_e;

endpackage

// File: rtl/ea_gen.sv
module ea_gen
    import mem_port_pkg::*;
(
    input  logic                en,
    input  mem_op_e             op,
    input  ld_size_e            ld_size,
    input  logic [WORD_W-1:0]   base,
    input  logic [OFS_W-1:0]    offset,
    output logic [WORD_W-1:0]   ea,
    output logic                misalign
);

    logic [WORD_W-1:0] ofs_ext;
    logic              need_word;
    logic              need_half;

    assign ofs_ext = {{(WORD_W-OFS_W){offset[OFS_W-1]}}, offset};
    assign ea      = base + ofs_ext;

    always_comb begin
        need_word = 1'b0;
        need_half = 1'b0;
        unique case (op)
            OP_FETCH: begin
                need_word = ld_size[1];
                need_half = (ld_size == SZ_HALF);
            end
            OP_ST_BYTE: ;
            OP_ST_HALF: need_half = 1'b1;
            OP_ST_WORD: need_word = 1'b1;
            default: ;
        endcase
        misalign = en && ((need_word && (ea[1:0] != 2'b00)) || (need_half && ea[0]));
    end

endmodule

// File: rtl/lane_ctl.sv
module lane_ctl
    import mem_port_pkg::*;
(
    input  logic                en,
    input  mem_op_e             op,
    input  logic [1:0]          byte_off,
    input  logic                misalign,
    input  logic [WORD_W-1:0]   wdata,
    output logic [LANES-1:0]    be,      // be[k] covers bits WORD_W-1-8k -: 8
    output logic [WORD_W-1:0]   wlanes
);

    logic store_ok;
    assign store_ok = en && !misalign && (op != OP_FETCH);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [1:0] KIDX = 2'(k);
        always_comb begin
            be[k] = 1'b0;
            wlanes[WORD_W-1-8*k -: 8] = wdata[WORD_W-1-8*k -: 8];
            unique case (op)
                OP_ST_BYTE: begin
                    be[k] = (byte_off == KIDX);
                    wlanes[WORD_W-1-8*k -: 8] = wdata[7:0];
                end
                OP_ST_HALF: begin
                    be[k] = (byte_off[1] == KIDX[1]);
                    wlanes[WORD_W-1-8*k -: 8] = KIDX[0] ? wdata[7:0] : wdata[15:8];
                end
                OP_ST_WORD: be[k] = 1'b1;
                OP_FETCH:   be[k] = 1'b0;
                default: ;
            endcase
            be[k] = be[k] && store_ok;
        end
    end

endmodule

// File: rtl/word_array.sv
module word_array
    import mem_port_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDXW-1:0]     idx,
    input  logic [LANES-1:0]    be,
    input  logic [WORD_W-1:0]   wlanes,
    output logic [WORD_W-1:0]   rword
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (be[k]) mem[idx][WORD_W-1-8*k -: 8] <= wlanes[WORD_W-1-8*k -: 8];
            end
        end
    end

    assign rword = mem[idx];

    // R6 / R4 / R5: a word that is not addressed by an enabled store holds its value
    for (genvar i = 0; i < DEPTH; i++) begin : g_hold
        p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(be != '0 && idx == IDXW'(i)) |=> $stable(mem[i]));
    end

endmodule

// File: rtl/load_align.sv
module load_align
    import mem_port_pkg::*;
(
    input  logic                en,
    input  mem_op_e             op,
    input  ld_size_e            ld_size,
    input  logic                ld_zext,
    input  logic [1:0]          byte_off,
    input  logic                misalign,
    input  logic [WORD_W-1:0]   rword,
    output logic [WORD_W-1:0]   rdata
);

    logic [7:0]  sel_byte;
    logic [15:0] sel_half;

    assign sel_byte = rword[WORD_W-1-8*byte_off -: 8];
    assign sel_half = byte_off[1] ? rword[15:0] : rword[31:16];

    always_comb begin
        rdata = '0;
        if (en && (op == OP_FETCH) && !misalign) begin
            unique case (ld_size)
                SZ_BYTE: rdata = {{24{sel_byte[7] & ~ld_zext}}, sel_byte};
                SZ_HALF: rdata = {{16{sel_half[15] & ~ld_zext}}, sel_half};
                SZ_WORD, SZ_WORD2: rdata = rword;
                default: rdata = rword;
            endcase
        end
    end

endmodule

// File: rtl/bytemem_port.sv
module bytemem_port
    import mem_port_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [1:0]   op,
    input  logic [31:0]  base,
    input  logic [15:0]  offset,
    input  logic [1:0]   ld_size,
    input  logic         ld_zext,
    input  logic [31:0]  wdata,
    output logic [31:0]  eff_addr,
    output logic [31:0]  rdata,
    output logic         misalign
);

    mem_op_e            op_e;
    ld_size_e           sz_e;
    logic [LANES-1:0]   be;
    logic [WORD_W-1:0]  wlanes;
    logic [WORD_W-1:0]  rword;

    assign op_e = mem_op_e'(op);
    assign sz_e = ld_size_e'(ld_size);

    ea_gen u_ea (
        .en(en), .op(op_e), .ld_size(sz_e), .base(base), .offset(offset),
        .ea(eff_addr), .misalign(misalign)
    );

    lane_ctl u_lane (
        .en(en), .op(op_e), .byte_off(eff_addr[1:0]), .misalign(misalign),
        .wdata(wdata), .be(be), .wlanes(wlanes)
    );

    word_array #(.DEPTH(DEPTH)) u_arr (
        .clk(clk), .rst_n(rst_n), .idx(eff_addr[IDXW+1:2]),
        .be(be), .wlanes(wlanes), .rword(rword)
    );

    load_align u_ld (
        .en(en), .op(op_e), .ld_size(sz_e), .ld_zext(ld_zext),
        .byte_off(eff_addr[1:0]), .misalign(misalign), .rword(rword), .rdata(rdata)
    );

    p_misalign_no_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (be == '0));
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (rdata == '0 && !misalign && be == '0));
    p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 2'b01) |-> $countones(be) == 1);
    p_word_all_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 2'b11 && !misalign) |-> be == '1);
    p_zext_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 2'b00 && ld_size == 2'b00 && ld_zext) |-> rdata[31:8] == '0);
    p_store_no_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 2'b00) |-> rdata == '0);

endmodule

// File: tb/test_bytemem_port.sv
module test_bytemem_port;

    localparam int DEPTH = 64;
    localparam int IDXW  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  op = '0;
    logic [31:0] base = '0;
    logic [15:0] offset = '0;
    logic [1:0]  ld_size = '0;
    logic        ld_zext = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] eff_addr;
    logic [31:0] rdata;
    logic        misalign;

    int total = 0;
    int bad = 0;
    logic [31:0] model [DEPTH];

    always #5 clk = ~clk;

    bytemem_port #(.DEPTH(DEPTH)) i_bytemem_port (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .base(base), .offset(offset),
        .ld_size(ld_size), .ld_zext(ld_zext), .wdata(wdata),
        .eff_addr(eff_addr), .rdata(rdata), .misalign(misalign)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_mis(logic [1:0] o, logic [1:0] sz, logic [31:0] a);
        case (o)
            2'b00:   return sz[1] ? (a[1:0] != 0) : (sz == 2'b01 ? a[0] : 1'b0);
            2'b10:   return a[0];
            2'b11:   return a[1:0] != 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_load(logic [31:0] w, logic [1:0] off,
                                             logic [1:0] sz, logic zx);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[31-8*off -: 8];
        h = off[1] ? w[15:0] : w[31:16];
        if (sz == 2'b00) return zx ? {24'h0, b} : {{24{b[7]}}, b};
        if (sz == 2'b01) return zx ? {16'h0, h} : {{16{h[15]}}, h};
        return w;
    endfunction

    task automatic access(string req, logic e, logic [1:0] o, logic [31:0] b,
                          logic [15:0] ofs, logic [1:0] sz, logic zx, logic [31:0] wd);
        logic [31:0] a;
        logic        m;
        logic [IDXW-1:0] ix;
        @(negedge clk);
        en = e; op = o; base = b; offset = ofs; ld_size = sz; ld_zext = zx; wdata = wd;
        a  = b + {{16{ofs[15]}}, ofs};
        m  = e && exp_mis(o, sz, a);
        ix = a[IDXW+1:2];
        #1;
        check(req, "eff_addr R1", eff_addr, a);
        check(req, "misalign", {31'h0, misalign}, {31'h0, m});
        check(req, "rdata", rdata, (e && o == 2'b00 && !m) ? exp_load(model[ix], a[1:0], sz, zx) : 32'h0);
        @(posedge clk);
        if (e && !m) begin
            case (o)
                2'b01: model[ix][31-8*a[1:0] -: 8] = wd[7:0];
                2'b10: if (a[1]) model[ix][15:0] = wd[15:0]; else model[ix][31:16] = wd[15:0];
                2'b11: model[ix] = wd;
                default: ;
            endcase
        end
    endtask

    task automatic rd_word(string req, logic [31:0] a);
        access(req, 1'b1, 2'b00, a, 16'h0, 2'b10, 1'b0, 32'h0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9: every word reads zero after reset
        for (int i = 0; i < DEPTH; i++) rd_word("R9", 32'(i * 4));

        // R5 and R2: aligned word store, then fetch
        access("R5", 1'b1, 2'b11, 32'h20, 16'h0, 2'b00, 1'b0, 32'h8A7F_C301);
        rd_word("R2", 32'h20);
        // R7: byte loads, sign and zero extension, each offset
        for (int k = 0; k < 4; k++) begin
            access("R7", 1'b1, 2'b00, 32'h20, 16'(k), 2'b00, 1'b0, 32'h0);
            access("R7", 1'b1, 2'b00, 32'h20, 16'(k), 2'b00, 1'b1, 32'h0);
        end
        // R8: halfword loads both halves, misaligned half
        access("R8", 1'b1, 2'b00, 32'h20, 16'h0, 2'b01, 1'b0, 32'h0);
        access("R8", 1'b1, 2'b00, 32'h22, 16'h0, 2'b01, 1'b1, 32'h0);
        access("R8", 1'b1, 2'b00, 32'h21, 16'h0, 2'b01, 1'b0, 32'h0);
        // R2: misaligned word fetch
        access("R2", 1'b1, 2'b00, 32'h22, 16'h0, 2'b10, 1'b0, 32'h0);
        // R3: byte store at offset 2, via negative displacement (R1)
        access("R3", 1'b1, 2'b01, 32'h26, 16'hFFFC, 2'b00, 1'b0, 32'hFFFF_FF5A);
        rd_word("R3", 32'h20);
        // R4: halfword stores, aligned low half and a misaligned one
        access("R4", 1'b1, 2'b10, 32'h22, 16'h0, 2'b00, 1'b0, 32'h1234_BEEF);
        access("R4", 1'b1, 2'b10, 32'h23, 16'h0, 2'b00, 1'b0, 32'h0000_0000);
        rd_word("R4", 32'h20);
        // R5: misaligned word store suppressed
        access("R5", 1'b1, 2'b11, 32'h21, 16'h0, 2'b00, 1'b0, 32'h0);
        rd_word("R5", 32'h20);
        // R6: disabled store and fetch
        access("R6", 1'b0, 2'b11, 32'h20, 16'h0, 2'b00, 1'b0, 32'hDEAD_0001);
        access("R6", 1'b0, 2'b00, 32'h21, 16'h0, 2'b10, 1'b0, 32'h0);
        rd_word("R6", 32'h20);
        // R10: rdata stays zero during stores
        access("R10", 1'b1, 2'b01, 32'h20, 16'h3, 2'b00, 1'b0, 32'h77);
        // R11: address aliasing above the index
        access("R11", 1'b1, 2'b11, 32'h0000_0100 + 32'h8, 16'h0, 2'b00, 1'b0, 32'hA5A5_0F0F);
        rd_word("R11", 32'h8);
        // R1: large negative displacement with wraparound
        access("R1", 1'b1, 2'b00, 32'h0000_0004, 16'h8000, 2'b10, 1'b0, 32'h0);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic        e;
            logic [1:0]  o, sz;
            logic [31:0] b;
            logic [15:0] ofs;
            string       tag;
            e   = ($urandom % 8) != 0;
            o   = 2'($urandom);
            sz  = 2'($urandom);
            b   = $urandom & 32'h0000_03FF;
            ofs = 16'(int'($urandom % 64) - 32);
            if (!e)              tag = "R6";
            else if (o == 2'b01) tag = "R3";
            else if (o == 2'b10) tag = "R4";
            else if (o == 2'b11) tag = "R5";
            else if (sz == 2'b00) tag = "R7";
            else if (sz == 2'b01) tag = "R8";
            else                 tag = "R2";
            access(tag, e, o, b, ofs, sz, 1'($urandom), $urandom);
        end

        // final sweep against the model
        for (int i = 0; i < DEPTH; i++) rd_word("R5", 32'(i * 4));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule